// File: doc/BRIEF.md
# Line Error and Alarm Interrupt Collector

This block gathers line and physical-layer indications into a single clear-on-read status word and drives one active-high interrupt line. Every bit of the word belongs to one of two classes. Error bits latch each time a single-cycle error pulse arrives on their input. Alarm bits latch whenever the level on their input changes, in either direction, after that level has passed through a synchroniser.

A processor reaches the block through a small register port. One address returns the status word and clears it as it is read; a second address holds a read/write mask that chooses which latched bits may drive the interrupt line. An event that lands in the same cycle as a clearing read stays latched for the next read, so no event is lost.

After reset the alarm change detector sits in a settling state (`ST_FILL`) while the synchroniser and the previous-value register fill with real input samples; the transition `FILL_DONE` moves it to `ST_RUN`, where alarm changes are reported. Error pulses latch in both states. No other transition exists apart from reset, which returns the detector to `ST_FILL`.

Top module: `line_irq_status`

## Requirements
- R1: After reset the status word, the enable mask, the interrupt output and the read data output are all zero.
- R2: Bit positions ERR_LO through ERR_HI (9 to 13 by default) are error bits: a one-cycle pulse on that position of the error input sets the bit at the next clock edge; pulses on any other position have no effect.
- R3: All other bit positions are alarm bits: a change of the alarm level in either direction sets the bit at the third rising edge after the new level is applied (two synchroniser stages plus the compare); level changes on error positions have no effect.
- R4: A read of address 0 returns the latched status word on the read data output one cycle later and clears every bit that was latched; a second read with no new event returns zero.
- R5: An event arriving in the same cycle as a clearing read is not returned by that read and stays latched for the following read.
- R6: The interrupt output is registered: it is high one cycle after any status bit is set together with its enable bit, and otherwise low.
- R7: Address 1 is the enable mask, readable and writable; a write to address 0 changes nothing.
- R8: An alarm level already present when reset is released does not set its status bit.
- R9: A read of any address other than 0 or 1 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| err_pulse_i | input | STAT_W | One-cycle error event per bit, synchronous to clk |
| alarm_lvl_i | input | STAT_W | Alarm levels, may be asynchronous |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address: 0 status, 1 enable mask |
| wdata_i | input | STAT_W | Write data |
| rdata_o | output | STAT_W | Registered read data, held between reads |
| irq_o | output | 1 | Active-high interrupt |

## Verification
On every cycle the assertions check that a status bit can drop only through a read, that a read leaves only same-cycle events behind, that new error bits trace back to an error pulse and new alarm bits to a change in the synchronised level, that no alarm event leaves the settling state, that the enable mask changes only on a write, and that the interrupt falls only two cycles after a read or a mask write. The exact latency of an alarm through the synchroniser, the returned read values, the survival of an event across a colliding read, and the suppression of a level held through reset are shown by the bench's directed scenarios and its randomly driven reference comparison.

// File: rtl/line_irq_pkg.sv
package line_irq_pkg;
    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } settle_e;

    localparam int unsigned REG_STATUS = 0;
    localparam int unsigned REG_ENABLE = 1;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/event_detect.sv
module event_detect
    import line_irq_pkg::*;
#(
    parameter int unsigned WIDTH       = 16,
    parameter int unsigned ERR_LO      = 9,
    parameter int unsigned ERR_HI      = 13,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] err_pulse_i,
    input  logic [WIDTH-1:0] alarm_sync_i,
    output logic [WIDTH-1:0] event_o,
    output logic             fill_o
);
    localparam int unsigned FILL_LEN = SYNC_STAGES + 1;
    localparam int unsigned CNT_W    = $clog2(FILL_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILL_LEN - 1);

    settle_e          state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] err_mask;
    logic             fill_done;
    logic             detect_en;

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_mask
            assign err_mask[g] = (g >= ERR_LO) && (g <= ERR_HI);
        end
    endgenerate

    assign fill_done = (cnt_q == CNT_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    // next state: FILL_DONE is the only transition
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (fill_done) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    // settling counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 cnt_q <= '0;
        else if (state_q == ST_FILL && !fill_done)  cnt_q <= cnt_q + 1'b1;
    end

    // previous synchronised alarm level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= alarm_sync_i;
    end

    // outputs of the state machine
    always_comb begin
        detect_en = 1'b0;
        fill_o    = 1'b0;
        unique case (state_q)
            ST_FILL: fill_o    = 1'b1;
            ST_RUN:  detect_en = 1'b1;
            default: fill_o    = 1'b1;
        endcase
    end

    always_comb begin
        event_o = err_pulse_i & err_mask;
        if (detect_en)
            event_o = event_o | ((alarm_sync_i ^ prev_q) & ~err_mask);
    end
endmodule

// File: rtl/status_latch.sv
module status_latch #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] event_i,
    input  logic             clear_i,
    output logic [WIDTH-1:0] status_o
);
    logic [WIDTH-1:0] status_q;
    logic [WIDTH-1:0] kept;

    // a clearing read drops the old bits; same-cycle events survive
    assign kept = clear_i ? '0 : status_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= kept | event_i;
    end

    assign status_o = status_q;
endmodule

// File: rtl/line_irq_status.sv
module line_irq_status
    import line_irq_pkg::*;
#(
    parameter int unsigned STAT_W      = 16,
    parameter int unsigned ERR_LO      = 9,
    parameter int unsigned ERR_HI      = 13,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] err_pulse_i,
    input  logic [STAT_W-1:0] alarm_lvl_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] rdata_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
    localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(REG_ENABLE);

    logic [STAT_W-1:0] alarm_sync;
    logic [STAT_W-1:0] events;
    logic [STAT_W-1:0] status_q;
    logic [STAT_W-1:0] enable_q;
    logic [STAT_W-1:0] rdata_q;
    logic              irq_q;
    logic              fill;
    logic              rd_status;
    logic              wr_enable;

    assign rd_status = rd_en_i && (addr_i == A_STATUS);
    assign wr_enable = wr_en_i && (addr_i == A_ENABLE);

    alarm_sync #(
        .WIDTH (STAT_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(alarm_lvl_i),
        .sync_o (alarm_sync)
    );

    event_detect #(
        .WIDTH      (STAT_W),
        .ERR_LO     (ERR_LO),
        .ERR_HI     (ERR_HI),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_detect (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_pulse_i (err_pulse_i),
        .alarm_sync_i(alarm_sync),
        .event_o     (events),
        .fill_o      (fill)
    );

    status_latch #(
        .WIDTH(STAT_W)
    ) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (events),
        .clear_i (rd_status),
        .status_o(status_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         enable_q <= '0;
        else if (wr_enable) enable_q <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en_i) begin
            if (addr_i == A_STATUS)      rdata_q <= status_q;
            else if (addr_i == A_ENABLE) rdata_q <= enable_q;
            else                         rdata_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(status_q & enable_q);
    end

    assign rdata_o = rdata_q;
    assign irq_o   = irq_q;
endmodule

// File: rtl/line_irq_status_chk.sv
module line_irq_status_chk #(
    parameter int unsigned STAT_W = 16,
    parameter int unsigned ERR_LO = 9,
    parameter int unsigned ERR_HI = 13,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] err_pulse_i,
    input logic              rd_en_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [STAT_W-1:0] rdata_o,
    input logic              irq_o,
    input logic [STAT_W-1:0] status_q,
    input logic [STAT_W-1:0] enable_q,
    input logic [STAT_W-1:0] events,
    input logic [STAT_W-1:0] alarm_sync,
    input logic              fill
);
    logic [STAT_W-1:0] emask;
    logic              rd_stat, wr_en_reg, rd_bad;

    for (genvar g = 0; g < STAT_W; g++) begin : g_m
        assign emask[g] = (g >= ERR_LO) && (g <= ERR_HI);
    end

    assign rd_stat   = rd_en_i && (addr_i == ADDR_W'(0));
    assign wr_en_reg = wr_en_i && (addr_i == ADDR_W'(1));
    assign rd_bad    = rd_en_i && (addr_i > ADDR_W'(1));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_stat) |-> ((status_q & $past(status_q)) == $past(status_q)));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_stat) |-> ((status_q & ~$past(events)) == '0));

    assert_err_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & emask & ~$past(err_pulse_i)) == '0));

    assert_alarm_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & ~$past(status_q) & ~emask
          & ~($past(alarm_sync) ^ $past(alarm_sync, 2))) == '0));

    assert_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> ((events & ~emask) == '0));

    assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en_reg) |-> $stable(enable_q));

    assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> ($past(rd_stat, 2) || $past(wr_en_reg, 2)));

    assert_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_bad) |-> (rdata_o == '0));
endmodule

bind line_irq_status line_irq_status_chk #(
    .STAT_W(STAT_W),
    .ERR_LO(ERR_LO),
    .ERR_HI(ERR_HI),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .err_pulse_i(err_pulse_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .rdata_o    (rdata_o),
    .irq_o      (irq_o),
    .status_q   (status_q),
    .enable_q   (enable_q),
    .events     (events),
    .alarm_sync (alarm_sync),
    .fill       (fill)
);

// File: tb/line_irq_status_tb.sv
module line_irq_status_tb;
    localparam int W = 16;
    localparam logic [W-1:0] EM = 16'h3E00;  // bits 9..13
    localparam logic [W-1:0] AM = ~EM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] err = '0, alm = '0, wdata = '0;
    logic rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = '0;
    logic [W-1:0] rdata;
    logic irq;

    int errors = 0, checks = 0;
    bit done = 0;

    // reference model
    logic [W-1:0] m_stat, m_en, m_rd, a1, a2, a3;
    logic m_irq;
    int edges;

    always #4 clk = ~clk;

    line_irq_status u_dut (
        .clk(clk), .rst_n(rst_n), .err_pulse_i(err), .alarm_lvl_i(alm),
        .rd_en_i(rd), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ev_of(input logic [W-1:0] e, input bit run);
        return (e & EM) | (run ? ((a2 ^ a3) & AM) : '0);
    endfunction

    task automatic model_reset();
        m_stat = '0; m_en = '0; m_rd = '0; a1 = '0; a2 = '0; a3 = '0;
        m_irq = 1'b0; edges = 0;
    endtask

    // one clock with the given inputs; at negedge afterwards compare
    task automatic cyc(input logic [W-1:0] e, input logic [W-1:0] al, input bit r,
                       input bit w, input logic [1:0] ad, input logic [W-1:0] wd);
        logic [W-1:0] ev, ns;
        err = e; alm = al; rd = r; wr = w; addr = ad; wdata = wd;
        @(posedge clk);
        ev = ev_of(e, edges >= 3);
        ns = ((r && ad == 2'd0) ? '0 : m_stat) | ev;
        if (r) m_rd = (ad == 2'd0) ? m_stat : (ad == 2'd1) ? m_en : '0;
        m_irq = |(m_stat & m_en);
        if (w && ad == 2'd1) m_en = wd;
        m_stat = ns;
        a3 = a2; a2 = a1; a1 = al;
        edges++;
        @(negedge clk);
        chk("R6 irq vs model", {15'd0, irq}, {15'd0, m_irq});
        if (r) chk(ad == 2'd0 ? "R4 status read vs model" : "R7/R9 read vs model", rdata, m_rd);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc('0, alm, 0, 0, 2'd0, '0);
    endtask

    task automatic rdstat(output logic [W-1:0] v);
        cyc('0, alm, 1, 0, 2'd0, '0);
        v = rdata;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'h5EED_1234));
        model_reset();
        alm = 16'h0004;  // R8: level present through reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 irq at reset", {15'd0, irq}, '0);
        chk("R1 rdata at reset", rdata, '0);
        rst_n = 1'b1;
        a1 = '0;
        idle(6);
        rdstat(v);  chk("R8 level held through reset not latched", v, '0);
        cyc('0, alm, 1, 0, 2'd1, '0); chk("R1 enable resets to zero", rdata, '0);

        // R7 enable read/write, status write ignored
        cyc('0, alm, 0, 1, 2'd1, 16'hA5C3);
        cyc('0, alm, 1, 0, 2'd1, '0); chk("R7 enable readback", rdata, 16'hA5C3);
        cyc('0, alm, 0, 1, 2'd0, 16'hFFFF);
        rdstat(v);  chk("R7 status write ignored", v, '0);
        cyc('0, alm, 0, 1, 2'd1, '0);

        // R2 error bits
        cyc(16'h0400, alm, 0, 0, 2'd0, '0);
        rdstat(v);  chk("R2 error bit 10 latched", v, 16'h0400);
        cyc(16'h0008, alm, 0, 0, 2'd0, '0);
        rdstat(v);  chk("R2 pulse on alarm position ignored", v, '0);

        // R3 alarm both edges
        alm = 16'h0000; idle(4);
        rdstat(v);  chk("R3 falling alarm latched", v, 16'h0004);
        rdstat(v);  chk("R4 second read cleared", v, '0);
        alm = 16'h0002; idle(2);
        rdstat(v);  chk("R3 not yet visible after two edges", v, '0);
        idle(1);
        rdstat(v);  chk("R3 rising alarm on third edge", v, 16'h0002);
        alm = 16'h0802; idle(4);
        rdstat(v);  chk("R3 level change on error position ignored", v, '0);

        // R5 event with clearing read
        cyc(16'h0200, alm, 0, 0, 2'd0, '0);
        cyc(16'h1000, alm, 1, 0, 2'd0, '0); chk("R5 read returns only old bits", rdata, 16'h0200);
        rdstat(v);  chk("R5 colliding event kept", v, 16'h1000);

        // R6 interrupt timing and masking
        cyc('0, alm, 0, 1, 2'd1, 16'h0200);
        cyc(16'h0200, alm, 0, 0, 2'd0, '0);
        chk("R6 irq still low at latch edge", {15'd0, irq}, '0);
        idle(1);
        chk("R6 irq high one cycle later", {15'd0, irq}, 16'h0001);
        rdstat(v); idle(1);
        chk("R6 irq low after clear", {15'd0, irq}, '0);
        cyc(16'h0400, alm, 0, 0, 2'd0, '0); idle(2);
        chk("R6 masked bit keeps irq low", {15'd0, irq}, '0);
        rdstat(v);

        // R9 unmapped
        cyc('0, alm, 1, 0, 2'd3, '0); chk("R9 unmapped read zero", rdata, '0);
        cyc('0, alm, 1, 0, 2'd2, '0); chk("R9 unmapped read zero", rdata, '0);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] e, al, wd;
            bit r, w;
            logic [1:0] ad;
            e  = (($urandom % 6) == 0) ? W'($urandom) & W'($urandom) : '0;
            al = (($urandom % 10) == 0) ? alm ^ (W'(1) << ($urandom % W)) : alm;
            r  = (($urandom % 5) == 0);
            w  = (($urandom % 30) == 0);
            ad = (($urandom % 4) == 0) ? 2'($urandom) : 2'd0;
            if (w) ad = 2'd1;
            wd = W'($urandom);
            cyc(e, al, r, w, ad, wd);
        end
        idle(5);
        rdstat(v);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule